// File: doc/BRIEF.md
# Row-In Column-Out Transpose Buffer

This block holds one square tile of fixed-width coefficients between the row pass and the column pass of a separable two-dimensional transform. On each write strobe a complete row enters from a wide input bus. The output bus always shows one complete column of the stored tile. The caller supplies no addresses. A write pointer picks the row that the next write fills, and a read pointer picks the column shown on the output. The write strobe advances the write pointer and the read strobe advances the read pointer.

A producer writes eight rows in order, and a consumer then steps through eight columns. The two pointers are independent, so writes and reads can interleave. When a write and a read happen in the same cycle, the column shown in that cycle still holds the tile as it was before the write. Reset returns both pointers to position 0 and leaves the stored tile untouched.

Top module: `tpose_mem`

## Requirements
- R1: While `rst` is high at a rising edge, both pointers become 0. Stored data is kept, so the first output after reset is column 0 of the previously stored tile.
- R2: A rising edge with `wr` high stores the whole `row_in` bus as the row at the write pointer. The write pointer then advances by one and wraps from 7 to 0.
- R3: Element k of either bus occupies bits [12k+11:12k], with element 0 in the least significant bits. Element r of `col_out` equals element c of stored row r, where c is the read pointer.
- R4: A rising edge with `rd` high advances the read pointer by one, wrapping from 7 to 0. `col_out` follows the pointer combinationally, so the next column appears right after that edge.
- R5: With `wr` and `rd` both low, the stored tile and both pointers stay unchanged, so `col_out` is stable whatever `row_in` carries.
- R6: When `wr` and `rd` are high together, `col_out` in that cycle shows the column as stored before the write. The write takes effect at the edge that ends the cycle.
- R7: The write pointer moves only on `wr` and the read pointer moves only on `rd`, so any interleaving of the two strobes keeps each sequence intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset of both pointers |
| wr | input | 1 | Store `row_in` at the write pointer and advance it |
| rd | input | 1 | Advance the read pointer to the next column |
| row_in | input | 96 | Eight 12-bit row elements |
| col_out | output | 96 | Eight 12-bit column elements, row 0 lowest |

## Verification
A write pointer that slips leaves a whole row of the tile in the wrong place. The first column read after that write then shows the misplaced element, because every column contains one element of every row. A read pointer that slips or fails to wrap changes `col_out` in the cycle right after the faulty `rd` edge. A write that lands early shows up in the simultaneous-strobe cycle as post-write data on the output. Because `col_out` is compared with the model on every clock, each of these faults is seen within one cycle of becoming visible at the output.

// File: rtl/tpose_pkg.sv
package tpose_pkg;
    // Elements per row and per column of the tile
    localparam int unsigned TP_DIM = 8;
    // Bits per element
    localparam int unsigned TP_EW  = 12;
endpackage

// File: rtl/tpose_seq_ctr.sv
// Wrapping position counter that advances on a strobe.
module tpose_seq_ctr #(
    parameter int unsigned DEPTH = 8
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     adv,
    output logic [(DEPTH > 1 ? $clog2(DEPTH) : 1)-1:0] pos
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (adv) begin
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end

    // R4
    pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && pos == LAST) |=> pos == '0);

    // R7
    pos_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && pos != LAST) |=> pos == PW'($past(pos) + 1'b1));

    // R7
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pos));
endmodule

// File: rtl/tpose_store.sv
// Row-written, column-read tile storage.
module tpose_store #(
    parameter int unsigned DIM = 8,
    parameter int unsigned EW  = 12
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   we,
    input  logic [(DIM > 1 ? $clog2(DIM) : 1)-1:0] wsel,
    input  logic [DIM*EW-1:0]                      wdata,
    input  logic [(DIM > 1 ? $clog2(DIM) : 1)-1:0] rsel,
    output logic [DIM*EW-1:0]                      rdata
);
    localparam int unsigned BUS = DIM * EW;

    logic [BUS-1:0] row_q [DIM];

    for (genvar r = 0; r < DIM; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (we && int'(wsel) == r) begin
                row_q[r] <= wdata;
            end
        end
        // Element r of the column is element rsel of row r
        assign rdata[r*EW +: EW] = row_q[r][int'(rsel)*EW +: EW];
    end

    // R2
    row_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> row_q[$past(wsel)] == $past(wdata));
endmodule

// File: rtl/tpose_mem.sv
// Addressless transpose buffer: rows in, columns out.
module tpose_mem #(
    parameter int unsigned DIM = tpose_pkg::TP_DIM,
    parameter int unsigned EW  = tpose_pkg::TP_EW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [DIM*EW-1:0] row_in,
    output logic [DIM*EW-1:0] col_out
);
    localparam int unsigned PW = (DIM > 1) ? $clog2(DIM) : 1;

    logic [PW-1:0] wr_row;
    logic [PW-1:0] rd_col;

    tpose_seq_ctr #(.DEPTH(DIM)) u_wr_ctr (
        .clk (clk),
        .rst (rst),
        .adv (wr),
        .pos (wr_row)
    );

    tpose_seq_ctr #(.DEPTH(DIM)) u_rd_ctr (
        .clk (clk),
        .rst (rst),
        .adv (rd),
        .pos (rd_col)
    );

    tpose_store #(.DIM(DIM), .EW(EW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr),
        .wsel  (wr_row),
        .wdata (row_in),
        .rsel  (rd_col),
        .rdata (col_out)
    );

    // R1
    ptr_reset_chk: assert property (@(posedge clk)
        rst |=> (wr_row == '0 && rd_col == '0));
endmodule

// File: tb/tpose_mem_bench.sv
`timescale 1ns/1ps
module tpose_mem_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr  = 1'b0;
    logic        rd  = 1'b0;
    logic [95:0] row_in = '0;
    logic [95:0] col_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int ref_mem [8][8];
    bit ref_v   [8][8];
    int wp = 0;
    int rp = 0;
    int lfsr = 32'h1ace;

    always #2.5 clk = ~clk;

    tpose_mem u_tpose_mem (
        .clk(clk), .rst(rst), .wr(wr), .rd(rd),
        .row_in(row_in), .col_out(col_out)
    );

    function automatic logic [95:0] mk_row(input int seed);
        logic [95:0] v;
        for (int k = 0; k < 8; k++) v[k*12 +: 12] = 12'((seed * 113 + k * 29 + 5) ^ (seed << 4));
        return v;
    endfunction

    task automatic check(input string tag);
        logic [95:0] exp_v;
        logic [95:0] act_v;
        bit bad;
        exp_v = '0;
        act_v = '0;
        bad = 0;
        for (int r = 0; r < 8; r++) begin
            if (ref_v[r][rp]) begin
                exp_v[r*12 +: 12] = 12'(ref_mem[r][rp]);
                act_v[r*12 +: 12] = col_out[r*12 +: 12];
                if (col_out[r*12 +: 12] !== 12'(ref_mem[r][rp])) bad = 1;
            end
        end
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s col=%0d actual=%h expected=%h", tag, rp, act_v, exp_v);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then update the model at the rising edge
    task automatic step(input bit w, input bit r, input logic [95:0] d, input string tag);
        @(negedge clk);
        wr = w; rd = r; row_in = d;
        #1;
        check(tag);
        @(posedge clk);
        if (w) begin
            for (int c = 0; c < 8; c++) begin
                ref_mem[wp][c] = int'(d[c*12 +: 12]);
                ref_v[wp][c] = 1;
            end
            wp = (wp + 1) % 8;
        end
        if (r) rp = (rp + 1) % 8;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; wr = 0; rd = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        wp = 0;
        rp = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: fill eight rows; the first wr after reset lands in row 0
        for (int i = 0; i < 8; i++) step(1, 0, mk_row(i + 1), "R2");
        // R3: read all columns, transpose with 12-bit element packing
        for (int i = 0; i < 8; i++) step(0, 1, '0, "R3");
        // R4: the read pointer wraps to column 0 and continues
        for (int i = 0; i < 8; i++) step(0, 1, '0, "R4");
        // R5: idle cycles with garbage on row_in leave the output untouched
        for (int i = 0; i < 4; i++) step(0, 0, {3{32'hdead_beef}}, "R5");
        // R2: write pointer wraps back to row 0 and overwrites it
        step(1, 0, mk_row(40), "R2");
        // R6: simultaneous write and read show pre-write data
        for (int i = 0; i < 6; i++) step(1, 1, mk_row(50 + i), "R6");
        // R7: random interleaving of independent strobes
        for (int i = 0; i < 60; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h8000_0057 : 0);
            step(lfsr[0], lfsr[1], mk_row(100 + i), "R7");
        end
        // R1: reset mid-stream clears pointers but keeps data
        step(1, 1, mk_row(300), "R7");
        do_reset();
        for (int i = 0; i < 8; i++) step(0, 1, '0, "R1");
        step(1, 0, mk_row(400), "R1");
        for (int i = 0; i < 8; i++) step(0, 1, '0, "R1");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule